// File: doc/BRIEF.md
# Four-Word Pattern Generator with State-as-Output Coding

The block steps endlessly through a fixed ring of four 4-bit words and has no data input. Each state is coded with the same bits it drives onto the output, so the register that holds the state is the output port itself. No decode logic sits between the flip-flops and the pins. The next word comes from four small sum-of-products equations that follow from this coding.

The ring is 0001, 0011, 1100, 1000, and then back to 0001. A synchronous reset starts the ring at 0001. An enable input lets the surrounding logic pause the pattern. If a soft error or a bad power-up leaves a code outside the ring in the register, the next clock returns it to 0001.

Top module: `seqgen_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, the output `wxyz` becomes 0001 after that edge.
- R2: With `en` high and `rst` low, each rising edge moves the output one step along 0001 → 0011 → 1100 → 1000 → 0001, where `wxyz[3]` is w and `wxyz[0]` is z.
- R3: With `en` low and `rst` low, a legal output word keeps its value across the edge.
- R4: The output is the state register itself, with no extra latency. The first enabled edge after reset gives 0011, and the pattern repeats with a period of exactly four enabled edges.
- R5: If the register holds any of the twelve codes outside the ring, the next rising edge loads 0001 whatever the level of `en`.
- R6: Reset takes priority over enable: `rst` high with `en` high still gives 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0001 |
| en | input | 1 | Advance enable; low holds the current word |
| wxyz | output | 4 | Current word, which is also the state; bit 3 is w |

## Verification
A behavioural reference steps an index through a four-entry word array and is compared with the output on every cycle. The comparison runs through long enabled stretches, irregular enable patterns and a reset in the middle of the ring. A design with a wrong equation term breaks the ring at one particular word. A design that ignores the enable would run ahead of the reference during a pause. Each of the twelve illegal codes is put into the register, with the enable both high and low. A design that relied only on the equations would stay locked at 0000, or would wander through codes outside the ring before it came back. A reset applied while enabled catches a priority error, because such a design would advance instead of restarting.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
  localparam int WORD_W  = 4;
  localparam int N_WORDS = 4;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t START_WORD = 4'b0001;
  localparam word_t RING_WORDS [N_WORDS] = '{4'b0001, 4'b0011, 4'b1100, 4'b1000};

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic advance;
  } ctrl_t;
endpackage

// File: rtl/seqgen_ctrl.sv
module seqgen_ctrl
  import seqgen_pkg::*;
(
  input  logic  rst,
  input  logic  en,
  input  word_t curWord,
  output ctrl_t ctrl
);
  logic [N_WORDS-1:0] matchVec;
  logic               isLegal;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_match
    assign matchVec[g] = (curWord == RING_WORDS[g]);
  end

  assign isLegal = |matchVec;

  always_comb begin
    ctrl.loadStart = rst | ~isLegal;
    ctrl.advance   = en & ~ctrl.loadStart;
  end
endmodule

// File: rtl/seqgen_datapath.sv
module seqgen_datapath
  import seqgen_pkg::*;
(
  input  logic  clk,
  input  ctrl_t ctrl,
  output word_t curWord
);
  word_t stateQ;
  word_t nextWord;

  // next-state equations for the output-coded ring
  always_comb begin
    nextWord[3] = stateQ[1] | stateQ[2];
    nextWord[2] = stateQ[1];
    nextWord[1] = ~stateQ[1] & stateQ[0];
    nextWord[0] = (~stateQ[1] & stateQ[0]) | (stateQ[3] & ~stateQ[2]);
  end

  always_ff @(posedge clk) begin
    if (ctrl.loadStart)
      stateQ <= START_WORD;
    else if (ctrl.advance)
      stateQ <= nextWord;
  end

  assign curWord = stateQ;
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
  import seqgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [3:0] wxyz
);
  ctrl_t ctrl;
  word_t curWord;

  seqgen_ctrl ctrl_i (
    .rst    (rst),
    .en     (en),
    .curWord(curWord),
    .ctrl   (ctrl)
  );

  seqgen_datapath dpath_i (
    .clk    (clk),
    .ctrl   (ctrl),
    .curWord(curWord)
  );

  assign wxyz = curWord;
endmodule

// File: rtl/seqgen_chk.sv
module seqgen_chk
  import seqgen_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  en,
  input word_t wxyz
);
  // set by a bench around deliberate state corruption
  logic skipCycle = 1'b0;

  function automatic logic inRing(word_t w);
    return (w == 4'b0001) || (w == 4'b0011) || (w == 4'b1100) || (w == 4'b1000);
  endfunction

  // R2
  step_a_chk: assert property (@(posedge clk) disable iff (rst || skipCycle)
    (en && wxyz == 4'b0001) |=> (wxyz == 4'b0011));
  // R2
  step_b_chk: assert property (@(posedge clk) disable iff (rst || skipCycle)
    (en && wxyz == 4'b0011) |=> (wxyz == 4'b1100));
  // R2
  step_c_chk: assert property (@(posedge clk) disable iff (rst || skipCycle)
    (en && wxyz == 4'b1100) |=> (wxyz == 4'b1000));
  // R4
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst || skipCycle)
    (en && wxyz == 4'b1000) |=> (wxyz == 4'b0001));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst || skipCycle)
    (!en && inRing(wxyz)) |=> $stable(wxyz));
  // R5
  recover_chk: assert property (@(posedge clk) disable iff (rst)
    !inRing(wxyz) |=> (wxyz == 4'b0001));
endmodule

bind seqgen_top seqgen_chk chk_i (
  .clk (clk),
  .rst (rst),
  .en  (en),
  .wxyz(wxyz)
);

// File: tb/seqgen_top_tb_top.sv
module seqgen_top_tb_top;
  import seqgen_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] wxyz;

  seqgen_top dut_i (.clk(clk), .rst(rst), .en(en), .wxyz(wxyz));

  always #4 clk = ~clk;

  word_t refSeq [4] = '{4'b0001, 4'b0011, 4'b1100, 4'b1000};
  int    idx = 0;
  bit    expBad = 1'b0;
  word_t badWord = '0;
  bit    armed = 1'b0;
  bit    done = 1'b0;
  string reqTag = "R1";
  int    compared = 0;
  int    mismatched = 0;

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      idx = 0;
      expBad = 1'b0;
    end else if (expBad) begin
      idx = 0;
      expBad = 1'b0;
    end else if (en) begin
      idx = (idx + 1) % 4;
    end
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      word_t expWord;
      expWord = expBad ? badWord : refSeq[idx];
      compared++;
      if (wxyz !== expWord) begin
        mismatched++;
        $display("FAIL %s: wxyz=%b expected=%b at %0t", reqTag, wxyz, expWord, $time);
      end
    end
  end

  task automatic runCycles(input int n, input bit e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = e;
    end
  endtask

  task automatic inject(input word_t v, input bit e);
    @(negedge clk);
    en = e;
    reqTag = "R5";
    @(posedge clk);
    #1;
    dut_i.chk_i.skipCycle = 1'b1;
    #1;
    badWord = v;
    expBad  = 1'b1;
    force dut_i.dpath_i.stateQ = v;
    release dut_i.dpath_i.stateQ;
    @(posedge clk);
    #1;
    dut_i.chk_i.skipCycle = 1'b0;
  endtask

  initial begin
    // R1: reset state
    reqTag = "R1";
    rst = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R4: first enabled edge gives 0011, then R2 ring over several periods
    reqTag = "R4";
    runCycles(1, 1'b1);
    reqTag = "R2";
    runCycles(23, 1'b1);

    // R3: irregular enable pattern
    reqTag = "R3";
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      en = ((i % 3) != 0) && ((i % 7) != 5);
    end
    runCycles(6, 1'b0);

    // R6: reset with enable high, mid-ring
    reqTag = "R2";
    runCycles(2, 1'b1);
    reqTag = "R6";
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    runCycles(2, 1'b1);

    // R5: every illegal code, enable high and low
    for (int c = 0; c < 16; c++) begin
      word_t w;
      w = word_t'(c);
      if (w != 4'b0001 && w != 4'b0011 && w != 4'b1100 && w != 4'b1000) begin
        inject(w, 1'b0);
        runCycles(2, 1'b1);
        inject(w, 1'b1);
        runCycles(3, 1'b1);
      end
    end

    // R2: long run after recovery
    reqTag = "R2";
    runCycles(400, 1'b1);

    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule